// File: doc/BRIEF.md
# Heartbeat Pixel Overlay

This block sits inline in a pixel stream and paints a small marker rectangle in the bottom-right corner of the active picture. The marker colour alternates between two parameter colours every `TOGGLE_FRAMES` frames. A viewer watching a frozen picture can then tell that the video pipeline is still running. Each pixel arrives with its column and row position. A one-cycle frame-start strobe marks frame boundaries. The output is the pixel, either passed through or replaced, one clock later, together with a flag that is high when the pixel was replaced.

Two controls gate the marker. A hardware switch input is the master gate. A soft enable, driven by decoded ASCII command bytes from a control port, sits under the switch. The soft enable only changes while the switch is on, so the switch acts as a hard off. The colour phase changes only on a frame-start strobe, so the marker colour is never torn within a frame.

Top module: `hb_pixel_overlay`

## Requirements
- R1: While reset is high and in the first cycle after it, `pix_out` is 0 and `ovl_active` is 0. Reset sets the soft enable to on and the colour phase to `COLOR_A`.
- R2: The marker covers columns `ACT_W-MARK_W` to `ACT_W-1` and rows `ACT_H-MARK_H` to `ACT_H-1`. While both enables are on, a pixel in that area leaves as the current phase colour one cycle later, with `ovl_active` high.
- R3: A pixel outside the marker area leaves unchanged one cycle later, with `ovl_active` low.
- R4: The phase starts at `COLOR_A` after reset and flips between `COLOR_A` and `COLOR_B` on every `TOGGLE_FRAMES`-th frame-start strobe.
- R5: The phase never changes in a cycle without a frame-start strobe. Every marker pixel of one frame therefore has the same colour.
- R6: While `sw_en` is low, every pixel passes through unchanged and `ovl_active` stays low.
- R7: With `sw_en` high, a valid command byte 0x53 ('S') or 0x73 ('s') turns the soft enable on, and 0x48 ('H') or 0x68 ('h') turns it off. The change shows from the next pixel on.
- R8: Command bytes that arrive while `sw_en` is low leave the soft enable unchanged. This is visible once the switch is back on.
- R9: Other byte values, and any byte with `cmd_valid` low, leave the soft enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | PIX_W | Input pixel data |
| x_pos | input | X_W | Column of `pix_in` in the active area |
| y_pos | input | Y_W | Row of `pix_in` in the active area |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| sw_en | input | 1 | Hardware switch, master enable |
| cmd_byte | input | 8 | Decoded control-port command byte |
| cmd_valid | input | 1 | `cmd_byte` is valid this cycle |
| pix_out | output | PIX_W | Output pixel, one cycle after input |
| ovl_active | output | 1 | High when `pix_out` is a marker pixel |

## Verification
A wrong soft enable shows as a frame with the marker wrongly present or wrongly missing. It becomes visible at the first marker pixel after the command. A phase counter that runs off or wraps at the wrong count shows as the wrong colour in the first frame after the expected flip. At worst this is `TOGGLE_FRAMES` frames late, so the sweep covers several flip periods. An off-by-one in the rectangle bounds shows on the edge rows and columns, and full-frame sweeps touch every one of them.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    HB_CMD_NONE,
    HB_CMD_SHOW,
    HB_CMD_HIDE
  } hb_cmd_e;

  localparam logic [7:0] ASCII_S_UP = 8'h53;
  localparam logic [7:0] ASCII_S_LO = 8'h73;
  localparam logic [7:0] ASCII_H_UP = 8'h48;
  localparam logic [7:0] ASCII_H_LO = 8'h68;

  // Case-insensitive map of a command byte onto the marker action.
  function automatic hb_cmd_e hb_decode(input logic [7:0] b);
    if (b == ASCII_S_UP || b == ASCII_S_LO) return HB_CMD_SHOW;
    if (b == ASCII_H_UP || b == ASCII_H_LO) return HB_CMD_HIDE;
    return HB_CMD_NONE;
  endfunction

endpackage

// File: rtl/hb_soft_enable.sv
module hb_soft_enable
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_en,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_valid,
  output logic       soft_en
);

  hb_cmd_e cmd;

  always_comb begin
    cmd = HB_CMD_NONE;
    if (cmd_valid && sw_en) cmd = hb_decode(cmd_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_en <= 1'b1;
    end else begin
      case (cmd)
        HB_CMD_SHOW: soft_en <= 1'b1;
        HB_CMD_HIDE: soft_en <= 1'b0;
        default:     soft_en <= soft_en;
      endcase
    end
  end

  // With the switch off, no command can alter the soft state.
  AST_SOFT_HOLD_SW_OFF: assert property (@(posedge clk) disable iff (rst)
    !sw_en |=> soft_en == $past(soft_en)); // R8

  // Without a valid strobe, the soft state holds.
  AST_SOFT_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> soft_en == $past(soft_en)); // R9

endmodule

// File: rtl/hb_phase_gen.sv
module hb_phase_gen #(
  parameter int TOGGLE_FRAMES = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic phase
);

  localparam int CNT_W = (TOGGLE_FRAMES > 1) ? $clog2(TOGGLE_FRAMES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOGGLE_FRAMES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (frame_start) begin
      if (cnt == CNT_LAST) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PHASE_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(phase)); // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST); // R4

endmodule

// File: rtl/hb_region.sv
module hb_region #(
  parameter int X_W    = 12,
  parameter int Y_W    = 12,
  parameter int ACT_W  = 1280,
  parameter int ACT_H  = 720,
  parameter int MARK_W = 16,
  parameter int MARK_H = 16
) (
  input  logic [X_W-1:0] x_pos,
  input  logic [Y_W-1:0] y_pos,
  output logic           in_mark
);

  localparam logic [X_W-1:0] X_LO = X_W'(ACT_W - MARK_W);
  localparam logic [X_W-1:0] X_HI = X_W'(ACT_W - 1);
  localparam logic [Y_W-1:0] Y_LO = Y_W'(ACT_H - MARK_H);
  localparam logic [Y_W-1:0] Y_HI = Y_W'(ACT_H - 1);

  always_comb begin
    in_mark = (x_pos >= X_LO) && (x_pos <= X_HI) &&
              (y_pos >= Y_LO) && (y_pos <= Y_HI);
  end

endmodule

// File: rtl/hb_pixel_overlay.sv
module hb_pixel_overlay #(
  parameter int              PIX_W         = 24,
  parameter int              X_W           = 12,
  parameter int              Y_W           = 12,
  parameter int              ACT_W         = 1280,
  parameter int              ACT_H         = 720,
  parameter int              MARK_W        = 16,
  parameter int              MARK_H        = 16,
  parameter int              TOGGLE_FRAMES = 30,
  parameter logic [PIX_W-1:0] COLOR_A      = '1,
  parameter logic [PIX_W-1:0] COLOR_B      = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [X_W-1:0]   x_pos,
  input  logic [Y_W-1:0]   y_pos,
  input  logic             frame_start,
  input  logic             sw_en,
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_valid,
  output logic [PIX_W-1:0] pix_out,
  output logic             ovl_active
);

  logic soft_en;
  logic phase;
  logic in_mark;
  logic paint;

  hb_soft_enable u_soft (
    .clk       (clk),
    .rst       (rst),
    .sw_en     (sw_en),
    .cmd_byte  (cmd_byte),
    .cmd_valid (cmd_valid),
    .soft_en   (soft_en)
  );

  hb_phase_gen #(.TOGGLE_FRAMES(TOGGLE_FRAMES)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .phase       (phase)
  );

  hb_region #(
    .X_W(X_W), .Y_W(Y_W), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .MARK_W(MARK_W), .MARK_H(MARK_H)
  ) u_region (
    .x_pos   (x_pos),
    .y_pos   (y_pos),
    .in_mark (in_mark)
  );

  // Switch is the master gate over the command-driven enable.
  assign paint = sw_en && soft_en && in_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out    <= '0;
      ovl_active <= 1'b0;
    end else begin
      pix_out    <= paint ? (phase ? COLOR_B : COLOR_A) : pix_in;
      ovl_active <= paint;
    end
  end

  AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !in_mark |=> (pix_out == $past(pix_in)) && !ovl_active); // R3

  AST_SWITCH_HARD_OFF: assert property (@(posedge clk) disable iff (rst)
    !sw_en |=> !ovl_active && (pix_out == $past(pix_in))); // R6

  AST_PAINT_COLOUR: assert property (@(posedge clk) disable iff (rst)
    ovl_active |-> (pix_out == COLOR_A) || (pix_out == COLOR_B)); // R2

endmodule

// File: tb/hb_pixel_overlay_tb_top.sv
`timescale 1ns/1ps
module hb_pixel_overlay_tb_top;

  localparam int PW = 24;
  localparam int XW = 12;
  localparam int YW = 12;
  localparam int AW = 8;
  localparam int AH = 6;
  localparam int MW = 3;
  localparam int MH = 2;
  localparam int TF = 3;
  localparam logic [PW-1:0] CA = 24'hF0F0F0;
  localparam logic [PW-1:0] CB = 24'h0F0F0F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] pix_in = '0;
  logic [XW-1:0] x_pos = '0;
  logic [YW-1:0] y_pos = '0;
  logic          frame_start = 1'b0;
  logic          sw_en = 1'b1;
  logic [7:0]    cmd_byte = '0;
  logic          cmd_valid = 1'b0;
  logic [PW-1:0] pix_out;
  logic          ovl_active;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  bit m_soft;
  bit m_phase;
  int m_cnt;

  always #2 clk = ~clk;

  hb_pixel_overlay #(
    .PIX_W(PW), .X_W(XW), .Y_W(YW), .ACT_W(AW), .ACT_H(AH),
    .MARK_W(MW), .MARK_H(MH), .TOGGLE_FRAMES(TF),
    .COLOR_A(CA), .COLOR_B(CB)
  ) dut_i (
    .clk(clk), .rst(rst), .pix_in(pix_in), .x_pos(x_pos), .y_pos(y_pos),
    .frame_start(frame_start), .sw_en(sw_en), .cmd_byte(cmd_byte),
    .cmd_valid(cmd_valid), .pix_out(pix_out), .ovl_active(ovl_active)
  );

  function automatic logic [PW-1:0] mk_pix(int x, int y);
    return PW'(32'hA50000 + y * 256 + x * 7 + 1);
  endfunction

  task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, check the registered result
  // at the next falling edge using the model state valid at the clock edge.
  task automatic step(int x, int y, bit fs, logic [7:0] cb, bit cv, string req);
    bit in_rect;
    bit paint;
    logic [PW-1:0] ep;
    logic [PW-1:0] p;
    p = mk_pix(x, y);
    pix_in = p; x_pos = XW'(x); y_pos = YW'(y);
    frame_start = fs; cmd_byte = cb; cmd_valid = cv;
    in_rect = (x >= AW - MW) && (x < AW) && (y >= AH - MH) && (y < AH);
    paint = sw_en && m_soft && in_rect;
    ep = paint ? (m_phase ? CB : CA) : p;
    @(negedge clk);
    chk(pix_out == ep, paint ? req : (in_rect ? req : "R3"), pix_out, ep);
    chk(ovl_active == paint, paint ? req : "R3 flag", PW'(ovl_active), PW'(paint));
    if (fs) begin
      m_cnt++;
      if (m_cnt == TF) begin m_cnt = 0; m_phase = ~m_phase; end
    end
    if (cv && sw_en) begin
      if (cb == 8'h53 || cb == 8'h73) m_soft = 1'b1;
      if (cb == 8'h48 || cb == 8'h68) m_soft = 1'b0;
    end
    frame_start = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic frame(string req);
    step(0, 0, 1'b1, 8'h00, 1'b0, req);
    for (int y = 0; y < AH; y++)
      for (int x = 0; x < AW; x++)
        step(x, y, 1'b0, 8'h00, 1'b0, req);
  endtask

  task automatic cmd(logic [7:0] b, bit v, string req);
    step(0, 0, 1'b0, b, v, req);
  endtask

  initial begin
    m_soft = 1'b1; m_phase = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(pix_out == '0, "R1 pix", pix_out, '0);
    chk(ovl_active == 1'b0, "R1 flag", PW'(ovl_active), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(pix_out == '0, "R1 post", pix_out, '0);
    // Several flip periods: R2 area, R4 toggle rate, R5 colour stable per frame
    for (int f = 0; f < 7; f++) frame("R2/R4/R5");
    // R7 both cases of each letter
    cmd(8'h68, 1'b1, "R7 h");
    frame("R7 off");
    cmd(8'h53, 1'b1, "R7 S");
    frame("R7 on");
    cmd(8'h48, 1'b1, "R7 H");
    frame("R7 off");
    cmd(8'h73, 1'b1, "R7 s");
    frame("R7 on");
    // R6 switch off
    sw_en = 1'b0;
    frame("R6");
    // R8 commands ignored while switch off
    cmd(8'h48, 1'b1, "R8");
    cmd(8'h68, 1'b1, "R8");
    sw_en = 1'b1;
    frame("R8 still on");
    cmd(8'h48, 1'b1, "R8 prep");
    sw_en = 1'b0;
    cmd(8'h53, 1'b1, "R8");
    sw_en = 1'b1;
    frame("R8 still off");
    cmd(8'h73, 1'b1, "R7 s");
    // R9 other bytes and invalid strobes
    cmd(8'h58, 1'b1, "R9");
    cmd(8'h48, 1'b0, "R9");
    cmd(8'h28, 1'b1, "R9");
    frame("R9 still on");
    for (int f = 0; f < 3; f++) frame("R4");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule